// File: doc/BRIEF.md
# Multi-Lane Playback RAM Sequencer

This block holds sample words for a transmit link of eight lanes. Each lane has its own RAM. Two 32-bit write ports load these RAMs. Port 0 serves the even lanes and port 1 serves the odd lanes. A 4-bit mask per port picks which of its lanes take part. Each port rotates through its enabled lanes and moves on after every word it writes. The samples therefore spread across the lanes in turn, which is the order a host sends them in.

A host drives three mutually exclusive controls: store, play and flush. Store loads words. Play loops each lane's stored words onto that lane's output without end. Flush discards everything and clears the status flags. Two status outputs tell the host whether anything is stored (empty) and whether a word was lost because a lane RAM was full (error).

Top module: `playback_ram_seq`

## Requirements
- R1: After reset every lane output is zero, `empty` is 1 and `error` is 0.
- R2: Port 0 mask bit i routes writes to lane 2i. Port 1 mask bit i routes writes to lane 2i+1.
- R3: Each accepted write moves the port to the next enabled mask bit, in ascending order with wrap-around. A store session starts at the lowest enabled bit. A port whose mask is 0000 discards its writes.
- R4: Words are written only in store mode. The first store cycle restarts every lane at address 0 and discards all earlier content. Writes presented outside store mode are ignored.
- R5: In the clock edge after play is first sampled, each lane outputs its word 0. Each following edge moves to the next stored word and wraps to word 0 after the last one, looping for as long as play is held. A lane with nothing stored outputs zero.
- R6: Whenever play is not active, all lane outputs are zero one edge later. Each new play command restarts at word 0.
- R7: A lane holds at most DEPTH words. Further writes to a full lane are dropped and set `error`, which stays set until a flush.
- R8: One edge after flush is sampled, all content is discarded, `empty` is 1 and `error` is 0.
- R9: `empty` drops to 0 one edge after the first accepted write.
- R10: Any cycle with more than one of play, store and flush set is treated as idle. No word is written, no lane plays and nothing is flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr0_valid | input | 1 | Port 0 write strobe |
| wr0_data | input | DATA_W | Port 0 write word |
| wr1_valid | input | 1 | Port 1 write strobe |
| wr1_data | input | DATA_W | Port 1 write word |
| mask0 | input | NUM_LANES/2 | Enabled even lanes (bit i = lane 2i) |
| mask1 | input | NUM_LANES/2 | Enabled odd lanes (bit i = lane 2i+1) |
| play | input | 1 | Play command |
| store | input | 1 | Store command |
| flush | input | 1 | Flush command |
| lane_data | output | NUM_LANES*DATA_W | Lane outputs, lane L at bits L*DATA_W upward |
| empty | output | 1 | Nothing stored |
| error | output | 1 | A write was dropped on a full lane |

## Verification
The bench builds the block with DEPTH set to 8, keeping eight 32-bit lanes. The small depth lets a ten-word burst into one lane overrun its RAM, so the drop and the sticky error are reached within a few cycles. It also lets playback pass the wrap point many times. The masks mix a sparse even set, a full odd set and an empty set, which exercises rotation, skipping and discard. A behavioural model of the lanes is compared with every output on every clock.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_STORE = 2'd1,
    MODE_PLAY  = 2'd2,
    MODE_FLUSH = 2'd3
  } pb_mode_e;
endpackage

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import pb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     play,
  input  logic     store,
  input  logic     flush,
  input  logic     any_accept,
  input  logic     any_overflow,
  output pb_mode_e mode,
  output logic     store_entry,
  output logic     empty,
  output logic     error
);
  logic store_q;
  logic [1:0] n_cmd;

  always_comb begin
    n_cmd = 2'($countones({play, store, flush}));
    mode  = MODE_IDLE;
    if (n_cmd == 2'd1) begin
      if (store)      mode = MODE_STORE;
      else if (play)  mode = MODE_PLAY;
      else            mode = MODE_FLUSH;
    end
  end

  assign store_entry = (mode == MODE_STORE) && !store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= 1'b0;
      empty   <= 1'b1;
      error   <= 1'b0;
    end else begin
      store_q <= (mode == MODE_STORE);
      if (mode == MODE_FLUSH) begin
        empty <= 1'b1;
        error <= 1'b0;
      end else begin
        if (store_entry)     empty <= !any_accept;
        else if (any_accept) empty <= 1'b0;
        if (any_overflow)    error <= 1'b1;
      end
    end
  end

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FLUSH) |=> (empty && !error));
  p_accept_fills_r9: assert property (@(posedge clk) disable iff (rst)
    any_accept |=> !empty);
  p_error_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (error && mode != MODE_FLUSH) |=> error);
endmodule

// File: rtl/pb_wr_rotator.sv
module pb_wr_rotator #(
  parameter int WAYS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            valid,
  input  logic [WAYS-1:0] mask,
  output logic [WAYS-1:0] we
);
  localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] sel;
  logic             found;

  always_comb begin
    int idx;
    sel   = '0;
    found = 1'b0;
    for (int k = 0; k < WAYS; k++) begin
      idx = int'(ptr) + k;
      if (idx >= WAYS) idx = idx - WAYS;
      if (!found && mask[idx]) begin
        found = 1'b1;
        sel   = PTR_W'(idx);
      end
    end
  end

  always_comb begin
    we = '0;
    if (active && valid && found) we[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      ptr <= '0;
    end else if (valid && found) begin
      ptr <= (sel == PTR_W'(WAYS - 1)) ? '0 : sel + 1'b1;
    end
  end

  p_we_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we));
  p_we_in_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (we & ~mask) == '0);
endmodule

// File: rtl/pb_lane.sv
module pb_lane #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              play_en,
  output logic              acc,
  output logic              ovf,
  output logic [DATA_W-1:0] q
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LEN_W  = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LEN_W-1:0]  len;
  logic [ADDR_W-1:0] rd;
  logic [ADDR_W-1:0] waddr;
  logic              full;

  assign full  = (len == LEN_W'(DEPTH));
  assign acc   = we && (clr || !full);
  assign ovf   = we && !clr && full;
  assign waddr = clr ? '0 : len[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (acc) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len <= '0;
    end else if (clr) begin
      len <= we ? LEN_W'(1) : '0;
    end else if (acc) begin
      len <= len + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !play_en) begin
      rd <= '0;
    end else if (len != '0) begin
      rd <= (({1'b0, rd} + 1'b1) >= len) ? '0 : rd + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !play_en || len == '0) q <= '0;
    else                              q <= mem[rd];
  end

  p_len_cap_r7: assert property (@(posedge clk) disable iff (rst)
    len <= LEN_W'(DEPTH));
  p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf) |=> $stable(len));
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !play_en |=> (q == '0));
  p_rd_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (len != '0) |-> ({1'b0, rd} < len));
endmodule

// File: rtl/playback_ram_seq.sv
module playback_ram_seq
  import pb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LANES = 8,
  parameter int DEPTH     = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr0_valid,
  input  logic [DATA_W-1:0]             wr0_data,
  input  logic                          wr1_valid,
  input  logic [DATA_W-1:0]             wr1_data,
  input  logic [NUM_LANES/2-1:0]        mask0,
  input  logic [NUM_LANES/2-1:0]        mask1,
  input  logic                          play,
  input  logic                          store,
  input  logic                          flush,
  output logic [NUM_LANES*DATA_W-1:0]   lane_data,
  output logic                          empty,
  output logic                          error
);
  localparam int PORT_LANES = NUM_LANES / 2;

  pb_mode_e              mode;
  logic                  store_entry;
  logic                  store_act;
  logic                  play_act;
  logic                  lane_clr;
  logic [PORT_LANES-1:0] we0;
  logic [PORT_LANES-1:0] we1;
  logic [NUM_LANES-1:0]  lane_we;
  logic [NUM_LANES-1:0]  lane_acc;
  logic [NUM_LANES-1:0]  lane_ovf;

  assign store_act = (mode == MODE_STORE);
  assign play_act  = (mode == MODE_PLAY);
  assign lane_clr  = store_entry || (mode == MODE_FLUSH);

  pb_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .play         (play),
    .store        (store),
    .flush        (flush),
    .any_accept   (|lane_acc),
    .any_overflow (|lane_ovf),
    .mode         (mode),
    .store_entry  (store_entry),
    .empty        (empty),
    .error        (error)
  );

  pb_wr_rotator #(.WAYS(PORT_LANES)) u_rot0 (
    .clk    (clk),
    .rst    (rst),
    .active (store_act),
    .valid  (wr0_valid),
    .mask   (mask0),
    .we     (we0)
  );

  pb_wr_rotator #(.WAYS(PORT_LANES)) u_rot1 (
    .clk    (clk),
    .rst    (rst),
    .active (store_act),
    .valid  (wr1_valid),
    .mask   (mask1),
    .we     (we1)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    if (g % 2 == 0) begin : g_even
      assign lane_we[g] = we0[g/2];
    end else begin : g_odd
      assign lane_we[g] = we1[g/2];
    end

    pb_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .clr     (lane_clr),
      .we      (lane_we[g]),
      .wdata   ((g % 2 == 0) ? wr0_data : wr1_data),
      .play_en (play_act),
      .acc     (lane_acc[g]),
      .ovf     (lane_ovf[g]),
      .q       (lane_q)
    );
    assign lane_data[g*DATA_W +: DATA_W] = lane_q;
  end

  p_illegal_idle_r10: assert property (@(posedge clk) disable iff (rst)
    ($countones({play, store, flush}) > 1) |-> (mode == MODE_IDLE && lane_we == '0));
  p_parity_split_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(lane_we) <= 2);
endmodule

// File: tb/playback_ram_seq_bench.sv
module playback_ram_seq_bench;
  localparam int DW = 32;
  localparam int NL = 8;
  localparam int DP = 8;

  logic clk = 1'b0;
  logic rst;
  logic wr0_valid, wr1_valid;
  logic [DW-1:0] wr0_data, wr1_data;
  logic [3:0] mask0, mask1;
  logic play, store, flush;
  logic [NL*DW-1:0] lane_data;
  logic empty, error;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #10 clk = ~clk;

  playback_ram_seq #(.DATA_W(DW), .NUM_LANES(NL), .DEPTH(DP)) u_playback_ram_seq (
    .clk(clk), .rst(rst),
    .wr0_valid(wr0_valid), .wr0_data(wr0_data),
    .wr1_valid(wr1_valid), .wr1_data(wr1_data),
    .mask0(mask0), .mask1(mask1),
    .play(play), .store(store), .flush(flush),
    .lane_data(lane_data), .empty(empty), .error(error)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane(input int l);
    return lane_data[l*DW +: DW];
  endfunction

  // behavioural reference model
  logic [31:0] m_mem [NL][DP];
  int          m_len [NL];
  int          m_rd  [NL];
  logic [31:0] m_out [NL];
  int          m_ptr [2];
  bit          m_prev, m_err, m_emp;
  int          ncmd, sel, ln;
  bit          st, pl, fl, fnd;
  logic [3:0]  msk;
  logic        vv;
  logic [31:0] dd;

  always @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NL; l++) begin m_len[l] = 0; m_rd[l] = 0; m_out[l] = 0; end
      m_ptr[0] = 0; m_ptr[1] = 0;
      m_prev = 0; m_err = 0; m_emp = 1;
    end else begin
      ncmd = int'(play) + int'(store) + int'(flush);
      st = store && ncmd == 1;
      pl = play  && ncmd == 1;
      fl = flush && ncmd == 1;
      if (st && !m_prev) for (int l = 0; l < NL; l++) m_len[l] = 0;
      for (int p = 0; p < 2; p++) begin
        msk = p ? mask1 : mask0;
        vv  = p ? wr1_valid : wr0_valid;
        dd  = p ? wr1_data : wr0_data;
        if (st && vv && msk != 0) begin
          fnd = 0; sel = 0;
          for (int k = 0; k < 4; k++)
            if (!fnd && msk[(m_ptr[p] + k) % 4]) begin fnd = 1; sel = (m_ptr[p] + k) % 4; end
          ln = 2 * sel + p;
          if (m_len[ln] < DP) begin m_mem[ln][m_len[ln]] = dd; m_len[ln]++; end
          else m_err = 1;
          m_ptr[p] = (sel + 1) % 4;
        end
        if (!st) m_ptr[p] = 0;
      end
      if (fl) begin
        for (int l = 0; l < NL; l++) m_len[l] = 0;
        m_err = 0;
      end
      m_emp = 1;
      for (int l = 0; l < NL; l++) if (m_len[l] != 0) m_emp = 0;
      for (int l = 0; l < NL; l++) begin
        if (pl) begin
          m_out[l] = (m_len[l] != 0) ? m_mem[l][m_rd[l]] : 32'h0;
          if (m_len[l] != 0) m_rd[l] = (m_rd[l] + 1 >= m_len[l]) ? 0 : m_rd[l] + 1;
        end else begin
          m_out[l] = 0; m_rd[l] = 0;
        end
      end
      m_prev = st;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int l = 0; l < NL; l++) check("R5 lane model", lane(l), m_out[l]);
      check("R9 empty model", {31'b0, empty}, {31'b0, m_emp});
      check("R7 error model", {31'b0, error}, {31'b0, m_err});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; play = 0; store = 0; flush = 0;
    wr0_valid = 0; wr1_valid = 0; wr0_data = 0; wr1_data = 0;
    mask0 = 0; mask1 = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 lanes zero", {31'b0, |lane_data}, 32'h0);
    check("R1 empty", {31'b0, empty}, 32'h1);
    check("R1 error", {31'b0, error}, 32'h0);

    // writes outside store are ignored
    mask0 = 4'b0101; mask1 = 4'b1111;
    wr0_valid = 1; wr1_valid = 1; wr0_data = 32'hC000_0000; wr1_data = 32'hC100_0000;
    repeat (2) @(negedge clk);
    check("R4 idle writes ignored", {31'b0, empty}, 32'h1);

    store = 1;
    for (int i = 0; i < 6; i++) begin
      wr0_data = 32'hA000_0000 + i; wr1_data = 32'hB000_0000 + i;
      @(negedge clk);
      if (i == 0) check("R9 empty drops", {31'b0, empty}, 32'h0);
    end
    wr0_valid = 0; wr1_valid = 0; store = 0;
    @(negedge clk);
    play = 1;
    @(negedge clk);
    check("R2 lane0 from port0", lane(0), 32'hA000_0000);
    check("R2 lane1 from port1", lane(1), 32'hB000_0000);
    check("R3 lane4 second even", lane(4), 32'hA000_0001);
    check("R3 lane7 fourth odd", lane(7), 32'hB000_0003);
    check("R5 unused lane2 zero", lane(2), 32'h0);
    @(negedge clk);
    check("R5 lane0 step", lane(0), 32'hA000_0002);
    check("R5 lane1 step", lane(1), 32'hB000_0004);
    @(negedge clk);
    check("R5 lane1 wrap", lane(1), 32'hB000_0000);
    repeat (10) @(negedge clk);
    play = 0;
    @(negedge clk);
    check("R6 idle zero", {31'b0, |lane_data}, 32'h0);
    play = 1;
    @(negedge clk);
    check("R6 restart word0", lane(0), 32'hA000_0000);
    play = 0;
    @(negedge clk);

    // illegal combination
    play = 1; store = 1; wr0_valid = 1; wr1_valid = 1;
    wr0_data = 32'hEE00_0000; wr1_data = 32'hEF00_0000;
    repeat (3) @(negedge clk);
    check("R10 no play", {31'b0, |lane_data}, 32'h0);
    check("R10 content kept", {31'b0, empty}, 32'h0);
    play = 0; store = 0; wr0_valid = 0; wr1_valid = 0;
    play = 1;
    @(negedge clk);
    check("R10 no write landed", lane(0), 32'hA000_0000);
    play = 0;
    @(negedge clk);

    // overflow into lane1, port 0 masked off
    mask0 = 4'b0000; mask1 = 4'b0001; store = 1;
    wr0_valid = 1; wr1_valid = 1;
    for (int i = 0; i < 10; i++) begin
      wr0_data = 32'h5500_0000 + i; wr1_data = 32'hD000_0000 + i;
      @(negedge clk);
      if (i == 7) check("R7 no error at depth", {31'b0, error}, 32'h0);
    end
    check("R7 overflow error", {31'b0, error}, 32'h1);
    wr0_valid = 0; wr1_valid = 0; store = 0;
    @(negedge clk);
    check("R7 error sticky", {31'b0, error}, 32'h1);
    play = 1;
    @(negedge clk);
    check("R4 old lane0 discarded", lane(0), 32'h0);
    check("R3 masked port0 dropped", lane(0) | lane(2) | lane(4) | lane(6), 32'h0);
    check("R4 lane1 restarts", lane(1), 32'hD000_0000);
    repeat (8) @(negedge clk);
    check("R7 dropped words absent", lane(1), 32'hD000_0000);
    play = 0;
    @(negedge clk);

    flush = 1;
    @(negedge clk);
    check("R8 empty set", {31'b0, empty}, 32'h1);
    check("R8 error cleared", {31'b0, error}, 32'h0);
    flush = 0; play = 1;
    @(negedge clk);
    check("R8 nothing plays", {31'b0, |lane_data}, 32'h0);
    play = 0;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule